// File: doc/BRIEF.md
# Terminal Character Flag Interface

This block sits between an accumulator-style processor and a character terminal. It holds one received character and one character waiting to be sent. Each of the two holding registers has a handshake flag. The receive flag means "a character is waiting for the processor". The transmit flag means "the device can take a new character". The processor drives the block with instruction strobes from its control unit. These instructions move characters between the holding registers and the low byte of the accumulator, test a flag and ask for a skip of the next instruction, or switch the interrupt enable.

On the device side, a received character arrives with a one-cycle valid. A character to send is offered with a valid that stays high until the device acknowledges it. The block raises an interrupt request whenever interrupts are enabled and either flag is set. The processor's interrupt cycle turns the enable off through a dedicated clear input.

All state is held in flops on one clock with a synchronous active-high reset. Every data output comes straight from a register, so each instruction's effect shows up on the ports one cycle after its strobe.

Top module: `term_io_port`

## Requirements
- R1: After reset, the receive flag is 0, the transmit flag is 1, transmit valid is 0, the interrupt enable is off, the overrun bit is 0, and `acc_ld`, `skip_req` and `irq_req` are 0.
- R2: An instruction acts only when `exec_stb` is 1 and `instr[15:12]` is 4'b1111. Bit 11 selects read-character, bit 10 write-character, bit 9 skip-on-receive-flag, bit 8 skip-on-transmit-flag, bit 7 enable-interrupts and bit 6 disable-interrupts. Several bits may be set together. Bits 5..0 are ignored.
- R3: A `rx_valid` pulse while the receive flag is 0 loads `rx_data` into the receive register, and the flag reads 1 on the next cycle.
- R4: A `rx_valid` pulse while the receive flag is 1 leaves the receive register unchanged and sets `rx_overrun`. A read-character clears `rx_overrun` unless a character is dropped in that same cycle.
- R5: A read-character gives `acc_ld`=1 on the next cycle, for one cycle, with `acc_din` equal to the receive register as it stood at the strobe. It clears the receive flag unless a character is accepted in that same cycle.
- R6: A write-character gives, on the next cycle, `tx_data` equal to `acc_lo` at the strobe, `tx_valid`=1 and transmit flag 0.
- R7: `tx_valid` and `tx_data` hold until a cycle with `tx_ack`=1 and no write-character. On the next cycle `tx_valid` is 0 and the transmit flag is 1. A write-character wins over a simultaneous acknowledge.
- R8: `skip_req` is 1 for the cycle after a strobe exactly when (bit 9 and receive flag = 1) or (bit 8 and transmit flag = 1), both taken at the strobe. Otherwise it is 0.
- R9: Enable-interrupts turns the enable on the next cycle. Disable-interrupts and `irq_clr` both turn it off and win over a simultaneous enable.
- R10: `irq_req` equals enable AND (receive flag OR transmit flag), formed from registers only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_stb | input | 1 | One-cycle strobe: execute `instr` |
| instr | input | 16 | Instruction word from the control unit |
| acc_lo | input | 8 | Low byte of the accumulator |
| acc_ld | output | 1 | Load `acc_din` into the accumulator low byte |
| acc_din | output | 8 | Character for the accumulator |
| skip_req | output | 1 | Request to skip the next instruction |
| irq_clr | input | 1 | Interrupt cycle: clear the enable |
| irq_req | output | 1 | Interrupt request |
| rx_valid | input | 1 | Device has a new character |
| rx_data | input | 8 | Received character |
| rx_flag | output | 1 | Receive flag |
| rx_overrun | output | 1 | A character was dropped |
| tx_data | output | 8 | Character to send |
| tx_valid | output | 1 | Character offered to the device |
| tx_ack | input | 1 | Device took the character |
| tx_flag | output | 1 | Transmit flag (device ready) |

## Verification
The assertions assume `exec_stb` and `rx_valid` are single-cycle pulses that are sampled on the rising edge. They also assume the device raises `tx_ack` only as a reply to a character it sees offered. The stimulus changes every input at the falling edge and holds it for exactly one rising edge. It acknowledges only while `tx_valid` is high, except in the deliberate cases where a write-character and an acknowledge collide. Collisions between arrival and read, enable and disable, and enable and interrupt clear are placed in single cycles, so that each priority rule is tested on its own.

// File: rtl/term_io_pkg.sv
package term_io_pkg;
  localparam int INSTR_W  = 16;
  localparam int GROUP_W  = 4;
  localparam int BIT_RD   = 11;
  localparam int BIT_WR   = 10;
  localparam int BIT_SKRX = 9;
  localparam int BIT_SKTX = 8;
  localparam int BIT_EN   = 7;
  localparam int BIT_DIS  = 6;

  typedef struct packed {
    logic rd_char;
    logic wr_char;
    logic skip_rx;
    logic skip_tx;
    logic int_on;
    logic int_off;
  } io_op_t;
endpackage

// File: rtl/term_io_decode.sv
module term_io_decode
  import term_io_pkg::*;
#(
  parameter int IW = INSTR_W
) (
  input  logic          stb,
  input  logic [IW-1:0] word,
  output io_op_t        op
);
  localparam logic [GROUP_W-1:0] GROUP_IO = '1;

  logic hit;
  assign hit = stb && (word[IW-1 -: GROUP_W] == GROUP_IO);

  always_comb begin
    op         = '0;
    op.rd_char = hit && word[BIT_RD];
    op.wr_char = hit && word[BIT_WR];
    op.skip_rx = hit && word[BIT_SKRX];
    op.skip_tx = hit && word[BIT_SKTX];
    op.int_on  = hit && word[BIT_EN];
    op.int_off = hit && word[BIT_DIS];
  end
endmodule

// File: rtl/term_io_rx.sv
module term_io_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          full,
  output logic          overrun,
  output logic          ld,
  output logic [DW-1:0] ld_data
);
  logic [DW-1:0] hold;
  logic          take, drop;

  assign take = in_valid && !full;
  assign drop = in_valid && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
      ld      <= 1'b0;
      ld_data <= '0;
    end else begin
      ld <= rd;
      if (rd) ld_data <= hold;
      if (take) begin
        hold <= in_data;
        full <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
      if (drop) overrun <= 1'b1;
      else if (rd) overrun <= 1'b0;
    end
  end

  AST_RX_LOAD: assert property (@(posedge clk) disable iff (rst)
    take |=> full && hold == $past(in_data)); // R3
  AST_RX_DROP: assert property (@(posedge clk) disable iff (rst)
    drop |=> $stable(hold) && overrun); // R4
  AST_RX_READ: assert property (@(posedge clk) disable iff (rst)
    rd |=> ld && ld_data == $past(hold)); // R5
endmodule

// File: rtl/term_io_tx.sv
module term_io_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] src,
  input  logic          ack,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      ready     <= 1'b1;
    end else if (wr) begin
      out_data  <= src;
      out_valid <= 1'b1;
      ready     <= 1'b0;
    end else if (ack && out_valid) begin
      out_valid <= 1'b0;
      ready     <= 1'b1;
    end
  end

  AST_TX_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr |=> out_valid && !ready && out_data == $past(src)); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !ack && !wr |=> out_valid && $stable(out_data)); // R7
  AST_TX_DONE: assert property (@(posedge clk) disable iff (rst)
    out_valid && ack && !wr |=> !out_valid && ready); // R7
endmodule

// File: rtl/term_io_ctl.sv
module term_io_ctl
  import term_io_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  io_op_t op,
  input  logic   rx_full,
  input  logic   tx_ready,
  input  logic   int_clr,
  output logic   skip,
  output logic   irq
);
  logic enable;
  logic skip_any;

  assign skip_any = op.skip_rx || op.skip_tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      skip   <= 1'b0;
    end else begin
      skip <= (op.skip_rx && rx_full) || (op.skip_tx && tx_ready);
      if (int_clr || op.int_off) enable <= 1'b0;
      else if (op.int_on) enable <= 1'b1;
    end
  end

  assign irq = enable && (rx_full || tx_ready);

  AST_SKIP_SRC: assert property (@(posedge clk) disable iff (rst)
    skip |-> $past(skip_any)); // R8
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
    int_clr |=> !irq); // R9
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    op.int_off |=> !irq); // R9
endmodule

// File: rtl/term_io_port.sv
module term_io_port
  import term_io_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = INSTR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec_stb,
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] acc_lo,
  output logic          acc_ld,
  output logic [DW-1:0] acc_din,
  output logic          skip_req,
  input  logic          irq_clr,
  output logic          irq_req,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_flag,
  output logic          rx_overrun,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ack,
  output logic          tx_flag
);
  io_op_t op;

  term_io_decode #(.IW(IW)) u_dec (
    .stb(exec_stb), .word(instr), .op(op)
  );

  term_io_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst), .rd(op.rd_char),
    .in_valid(rx_valid), .in_data(rx_data),
    .full(rx_flag), .overrun(rx_overrun),
    .ld(acc_ld), .ld_data(acc_din)
  );

  term_io_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst), .wr(op.wr_char), .src(acc_lo),
    .ack(tx_ack), .out_data(tx_data), .out_valid(tx_valid),
    .ready(tx_flag)
  );

  term_io_ctl u_ctl (
    .clk(clk), .rst(rst), .op(op), .rx_full(rx_flag),
    .tx_ready(tx_flag), .int_clr(irq_clr),
    .skip(skip_req), .irq(irq_req)
  );

  AST_NO_ACT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !exec_stb |=> !acc_ld && !skip_req); // R2
  AST_LD_PULSE: assert property (@(posedge clk) disable iff (rst)
    acc_ld |-> $past(exec_stb)); // R5
endmodule

// File: tb/sim_term_io_port.sv
module sim_term_io_port;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic stb; logic [15:0] ins; logic [7:0] acc;
    logic rxv; logic [7:0] rxd; logic ack; logic iclr;
    logic e_ld; logic [7:0] e_din; logic e_skp; logic e_rxf;
    logic e_txr; logic e_txv; logic [7:0] e_txd; logic e_irq; logic e_ovr;
  } vec_t;

  // stb ins acc rxv rxd ack iclr | ld din skp rxf txr txv txd irq ovr
  localparam vec_t TBL [NV] = '{
    '{1'b1,16'hF100,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0}, // R8 skip tx
    '{1'b1,16'hF200,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,1'b0}, // R8 no skip
    '{1'b0,16'h0000,8'h00,1'b1,8'h41,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0}, // R3 arrive
    '{1'b1,16'hF200,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,8'h00,1'b0,1'b0}, // R8 skip rx
    '{1'b1,16'hF080,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h00,1'b1,1'b0}, // R9 on
    '{1'b0,16'h0000,8'h00,1'b1,8'h42,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b1,1'b1,1'b0,8'h00,1'b1,1'b1}, // R4 drop
    '{1'b1,16'hF800,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h41,1'b0,1'b0,1'b1,1'b0,8'h00,1'b1,1'b0}, // R5 read
    '{1'b1,16'hF400,8'h5A,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h5A,1'b0,1'b0}, // R6 write
    '{1'b1,16'hF104,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h5A,1'b0,1'b0}, // R2 low bits
    '{1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h5A,1'b0,1'b0}, // R7 hold
    '{1'b0,16'h0000,8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,1'b1,1'b0}, // R7 ack
    '{1'b1,16'h7800,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,1'b1,1'b0}, // R2 group
    '{1'b0,16'h0000,8'h00,1'b0,8'h00,1'b0,1'b1, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,1'b0,1'b0}, // R9 clr
    '{1'b1,16'hF0C0,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,1'b0,1'b0}, // R9 off wins
    '{1'b1,16'hF080,8'h00,1'b0,8'h00,1'b0,1'b1, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,1'b0,1'b0}, // R9 clr wins
    '{1'b1,16'hF080,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h5A,1'b1,1'b0}, // R10
    '{1'b1,16'hF800,8'h00,1'b1,8'h33,1'b0,1'b0, 1'b1,8'h41,1'b0,1'b1,1'b1,1'b0,8'h5A,1'b1,1'b0}, // R5 take wins
    '{1'b1,16'hF240,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b1,1'b1,1'b1,1'b0,8'h5A,1'b0,1'b0}, // R2 multi
    '{1'b1,16'hF800,8'h00,1'b1,8'h77,1'b0,1'b0, 1'b1,8'h33,1'b0,1'b0,1'b1,1'b0,8'h5A,1'b0,1'b1}, // R4 drop wins
    '{1'b1,16'hF400,8'h12,1'b0,8'h00,1'b1,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h12,1'b0,1'b1}, // R6
    '{1'b1,16'hF400,8'h34,1'b0,8'h00,1'b1,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h34,1'b0,1'b1}, // R7 wr wins
    '{1'b0,16'h0000,8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h34,1'b0,1'b1}, // R7
    '{1'b1,16'hF800,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b1,8'h33,1'b0,1'b0,1'b1,1'b0,8'h34,1'b0,1'b0}, // R4 clear
    '{1'b0,16'hF800,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h34,1'b0,1'b0}  // R2 no strobe
  };

  logic clk = 1'b0, rst = 1'b1;
  logic exec_stb = 1'b0, irq_clr = 1'b0, rx_valid = 1'b0, tx_ack = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0] acc_lo = '0, rx_data = '0;
  logic acc_ld, skip_req, irq_req, rx_flag, rx_overrun, tx_valid, tx_flag;
  logic [7:0] acc_din, tx_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_io_port u0 (
    .clk(clk), .rst(rst), .exec_stb(exec_stb), .instr(instr), .acc_lo(acc_lo),
    .acc_ld(acc_ld), .acc_din(acc_din), .skip_req(skip_req), .irq_clr(irq_clr),
    .irq_req(irq_req), .rx_valid(rx_valid), .rx_data(rx_data), .rx_flag(rx_flag),
    .rx_overrun(rx_overrun), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ack(tx_ack), .tx_flag(tx_flag)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    exec_stb = v.stb; instr = v.ins; acc_lo = v.acc;
    rx_valid = v.rxv; rx_data = v.rxd; tx_ack = v.ack; irq_clr = v.iclr;
  endtask

  task automatic check_reset_state();
    check("R1 rx_flag", {7'd0, rx_flag}, 8'd0);
    check("R1 tx_flag", {7'd0, tx_flag}, 8'd1);
    check("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
    check("R1 irq_req", {7'd0, irq_req}, 8'd0);
    check("R1 rx_overrun", {7'd0, rx_overrun}, 8'd0);
    check("R1 acc_ld", {7'd0, acc_ld}, 8'd0);
    check("R1 skip_req", {7'd0, skip_req}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      check("R5 acc_ld", {7'd0, acc_ld}, {7'd0, TBL[i].e_ld});
      if (TBL[i].e_ld) check("R5 acc_din", acc_din, TBL[i].e_din);
      check("R8 skip_req", {7'd0, skip_req}, {7'd0, TBL[i].e_skp});
      check("R3 rx_flag", {7'd0, rx_flag}, {7'd0, TBL[i].e_rxf});
      check("R7 tx_flag", {7'd0, tx_flag}, {7'd0, TBL[i].e_txr});
      check("R7 tx_valid", {7'd0, tx_valid}, {7'd0, TBL[i].e_txv});
      check("R6 tx_data", tx_data, TBL[i].e_txd);
      check("R10 irq_req", {7'd0, irq_req}, {7'd0, TBL[i].e_irq});
      check("R4 rx_overrun", {7'd0, rx_overrun}, {7'd0, TBL[i].e_ovr});
    end
    // Directed: build up state, then reset mid-run (R1)
    drive('{1'b1,16'hF080,8'h00,1'b0,8'h00,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0});
    @(negedge clk);
    drive('{1'b1,16'hF400,8'h66,1'b1,8'h55,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0});
    @(negedge clk);
    drive('{1'b0,16'h0000,8'h00,1'b1,8'h99,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0});
    @(negedge clk);
    check("R10 irq before reset", {7'd0, irq_req}, 8'd1);
    check("R4 overrun before reset", {7'd0, rx_overrun}, 8'd1);
    drive('0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_reset_state();
    check("R1 tx_data", tx_data, 8'd0);
    // R9: enable off after reset, so a set flag must not request an interrupt
    drive('{1'b0,16'h0000,8'h00,1'b1,8'h21,1'b0,1'b0, 1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,1'b0});
    @(negedge clk);
    drive('0);
    check("R9 enable cleared by reset", {7'd0, irq_req}, 8'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule